// File: doc/BRIEF.md
# Sector Erase Batch Window

This block gathers the sectors of a multi-sector erase into one batch. An upstream command decoder pulses `seq_open` when the full sector-erase command sequence has been written, together with the sector that sequence named. That opens an acceptance window of `WIN_CYC` clock cycles. While the window is open, every bus write is seen on `wr_valid`/`wr_data`/`wr_sector`. A write carrying the sector-erase code (`CMD_SECT`, 30h by default) adds its sector to an `NSECT`-bit selection mask and starts the full window again. Any other write cancels the batch and asks the surrounding logic to return to array reads.

When the window runs out with no write in its last cycle, the block emits a one-cycle start pulse that carries the final mask to the erase engine. It then stays in the erase phase, ignoring every write and every new `seq_open`, until the engine reports `erase_done`. Two status levels feed the status byte. `sts_closed` is the bit-3 value: 0 while sectors can still be added, 1 once the erase has begun. `sts_toggle` marks that the toggle bit must be active, which covers both the window and the erase.

Commands arrive as single-cycle write events and are never back-pressured. There is no ready signal: a write that the block does not want is consumed and has no effect. Chip erase does not pass through this block.

Top module: `sect_batch_win`

## Requirements
- R1: After reset `sts_closed`, `sts_toggle`, `start_pulse`, `abort_pulse` and `start_mask` are all 0.
- R2: A `seq_open` pulse while idle opens the window. From the next cycle `sts_toggle`=1 and `sts_closed`=0, and the mask holds only bit `seq_sector` (bit i stands for sector i).
- R3: If no write arrives, `start_pulse` goes to 1 in the cycle after the `WIN_CYC`-th rising edge that follows the edge which accepted the last sector, and `start_mask` then carries the mask.
- R4: A write with `wr_data`=`CMD_SECT` inside the window sets mask bit `wr_sector` and restarts the full `WIN_CYC` window from that edge.
- R5: Naming a sector that is already in the mask leaves the mask unchanged, but still restarts the window.
- R6: Sectors may be added in any order, up to all `NSECT`. With every sector named, the start mask is all ones.
- R7: A write with any other data value inside the window raises `abort_pulse` for one cycle, clears the mask, returns to idle (`sts_toggle`=0) and produces no start pulse.
- R8: `sts_closed`=1 from the start pulse until `erase_done`. `sts_toggle`=1 through both the window and the erase.
- R9: During the erase phase every write and every `seq_open` is ignored: no abort, no new window, no start. After `erase_done` the block is idle.
- R10: A write that arrives on the edge where the window would expire takes priority. An erase code adds its sector and restarts the window; any other code aborts. No start pulse follows that edge.
- R11: `start_pulse` lasts exactly one cycle, and `start_mask` is 0 whenever `start_pulse` is 0.
- R12: While idle, writes without `seq_open` open no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seq_open | input | 1 | Full sector-erase sequence just completed |
| seq_sector | input | SW (3) | Sector named by that sequence |
| wr_valid | input | 1 | A bus write occurs this cycle |
| wr_data | input | DW (8) | Data of the bus write |
| wr_sector | input | SW (3) | Sector field of the write address |
| erase_done | input | 1 | Erase engine finished the batch |
| start_pulse | output | 1 | One-cycle request to erase the batch |
| start_mask | output | NSECT (8) | Sectors to erase, valid with start_pulse |
| abort_pulse | output | 1 | Batch cancelled, return to array read |
| sts_closed | output | 1 | Status bit 3: window closed, erase running |
| sts_toggle | output | 1 | Toggle bit must be active |

## Verification
Window expiry and an incoming write can land on the same clock edge, and both want to change the state. The bench provokes this by counting exactly `WIN_CYC-1` cycles after opening and then placing a write on the expiring edge, once with the erase code and once with another code. It judges the outcome by seeing no start pulse on the next cycle. In the erase-code case it also checks for a fresh full window that ends with the combined mask. In the other case it checks for the abort pulse and the return to idle.

// File: rtl/sect_batch_pkg.sv
package sect_batch_pkg;
  typedef enum logic [1:0] {
    SB_IDLE   = 2'd0,
    SB_WINDOW = 2'd1,
    SB_ERASE  = 2'd2
  } sb_state_e;
endpackage

// File: rtl/sect_batch_timer.sv
// Retriggerable window counter: counts while run is high, expired flags the final cycle.
module sect_batch_timer #(
  parameter int unsigned WIN_CYC = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic expired
);
  localparam int unsigned CW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;

  logic [CW-1:0] cnt;

  assign expired = run && (cnt == CW'(WIN_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || restart)  cnt <= '0;
    else if (!expired)         cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/sect_batch_mask.sv
// Selection mask: load replaces with one sector, add ORs one sector in, clr empties.
module sect_batch_mask #(
  parameter int unsigned NSECT = 8,
  localparam int unsigned SW   = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             add,
  input  logic             clr,
  input  logic [SW-1:0]    idx,
  output logic [NSECT-1:0] mask
);
  for (genvar g = 0; g < NSECT; g++) begin : g_bit
    logic hit;
    assign hit = (idx == SW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mask[g] <= 1'b0;
      else if (clr)        mask[g] <= 1'b0;
      else if (load)       mask[g] <= hit;
      else if (add && hit) mask[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/sect_batch_ctrl.sv
// Phase control: idle, accepting window, erase running.
module sect_batch_ctrl
  import sect_batch_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      seq_open,
  input  logic      wr_valid,
  input  logic      wr_is_sect,
  input  logic      erase_done,
  input  logic      expired,
  output sb_state_e state,
  output logic      timer_run,
  output logic      timer_restart,
  output logic      mask_load,
  output logic      mask_add,
  output logic      mask_clr,
  output logic      start_fire,
  output logic      abort_fire
);
  sb_state_e nxt;

  always_comb begin
    nxt           = state;
    timer_run     = 1'b0;
    timer_restart = 1'b0;
    mask_load     = 1'b0;
    mask_add      = 1'b0;
    mask_clr      = 1'b0;
    start_fire    = 1'b0;
    abort_fire    = 1'b0;
    unique case (state)
      SB_IDLE: begin
        if (seq_open) begin
          mask_load = 1'b1;
          nxt       = SB_WINDOW;
        end
      end
      SB_WINDOW: begin
        timer_run = 1'b1;
        // a write on the expiring edge wins over the expiry
        if (wr_valid) begin
          if (wr_is_sect) begin
            mask_add      = 1'b1;
            timer_restart = 1'b1;
          end else begin
            abort_fire = 1'b1;
            mask_clr   = 1'b1;
            nxt        = SB_IDLE;
          end
        end else if (expired) begin
          start_fire = 1'b1;
          nxt        = SB_ERASE;
        end
      end
      SB_ERASE: begin
        if (erase_done) begin
          mask_clr = 1'b1;
          nxt      = SB_IDLE;
        end
      end
      default: nxt = SB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SB_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/sect_batch_win.sv
module sect_batch_win
  import sect_batch_pkg::*;
#(
  parameter int unsigned NSECT    = 8,
  parameter int unsigned DW       = 8,
  parameter int unsigned WIN_CYC  = 5000,
  parameter logic [DW-1:0] CMD_SECT = 8'h30,
  localparam int unsigned SW      = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seq_open,
  input  logic [SW-1:0]    seq_sector,
  input  logic             wr_valid,
  input  logic [DW-1:0]    wr_data,
  input  logic [SW-1:0]    wr_sector,
  input  logic             erase_done,
  output logic             start_pulse,
  output logic [NSECT-1:0] start_mask,
  output logic             abort_pulse,
  output logic             sts_closed,
  output logic             sts_toggle
);
  sb_state_e        state;
  logic             timer_run, timer_restart, expired;
  logic             mask_load, mask_add, mask_clr;
  logic             start_fire, abort_fire;
  logic             wr_is_sect;
  logic [SW-1:0]    idx;
  logic [NSECT-1:0] mask;

  assign wr_is_sect = (wr_data == CMD_SECT);
  assign idx        = (state == SB_IDLE) ? seq_sector : wr_sector;

  sect_batch_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .seq_open      (seq_open),
    .wr_valid      (wr_valid),
    .wr_is_sect    (wr_is_sect),
    .erase_done    (erase_done),
    .expired       (expired),
    .state         (state),
    .timer_run     (timer_run),
    .timer_restart (timer_restart),
    .mask_load     (mask_load),
    .mask_add      (mask_add),
    .mask_clr      (mask_clr),
    .start_fire    (start_fire),
    .abort_fire    (abort_fire)
  );

  sect_batch_timer #(.WIN_CYC(WIN_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (timer_run),
    .restart (timer_restart),
    .expired (expired)
  );

  sect_batch_mask #(.NSECT(NSECT)) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (mask_load),
    .add   (mask_add),
    .clr   (mask_clr),
    .idx   (idx),
    .mask  (mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_pulse <= 1'b0;
      start_mask  <= '0;
      abort_pulse <= 1'b0;
    end else begin
      start_pulse <= start_fire;
      start_mask  <= start_fire ? mask : '0;
      abort_pulse <= abort_fire;
    end
  end

  assign sts_closed = (state == SB_ERASE);
  assign sts_toggle = (state != SB_IDLE);
endmodule

// File: rtl/sect_batch_win_chk.sv
module sect_batch_win_chk #(
  parameter int unsigned NSECT = 8,
  parameter int unsigned DW    = 8,
  parameter logic [DW-1:0] CMD_SECT = 8'h30
) (
  input logic             clk,
  input logic             rst_n,
  input logic             seq_open,
  input logic             wr_valid,
  input logic [DW-1:0]    wr_data,
  input logic             erase_done,
  input logic             start_pulse,
  input logic [NSECT-1:0] start_mask,
  input logic             abort_pulse,
  input logic             sts_closed,
  input logic             sts_toggle
);
  logic in_window;
  assign in_window = sts_toggle && !sts_closed;

  // R2
  open_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts_toggle && seq_open) |=> (sts_toggle && !sts_closed));

  // R3
  start_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (start_mask != '0));

  // R10
  sect_write_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_window && wr_valid && wr_data == CMD_SECT) |=> (!start_pulse && in_window));

  // R7
  other_write_aborts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_window && wr_valid && wr_data != CMD_SECT) |=> (abort_pulse && !sts_toggle && !start_pulse));

  // R8
  start_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (sts_closed && sts_toggle));

  // R9
  erase_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_closed && !erase_done) |=> (sts_closed && !abort_pulse));

  // R11
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  // R11
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_pulse |-> (start_mask == '0));
endmodule

bind sect_batch_win sect_batch_win_chk #(.NSECT(NSECT), .DW(DW), .CMD_SECT(CMD_SECT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .seq_open    (seq_open),
  .wr_valid    (wr_valid),
  .wr_data     (wr_data),
  .erase_done  (erase_done),
  .start_pulse (start_pulse),
  .start_mask  (start_mask),
  .abort_pulse (abort_pulse),
  .sts_closed  (sts_closed),
  .sts_toggle  (sts_toggle)
);

// File: tb/sect_batch_win_bench.sv
module sect_batch_win_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       seq_open = 1'b0;
  logic [2:0] seq_sector = '0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic [2:0] wr_sector = '0;
  logic       erase_done = 1'b0;
  logic       start_pulse, abort_pulse, sts_closed, sts_toggle;
  logic [7:0] start_mask;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sect_batch_win #(.NSECT(8), .DW(8), .WIN_CYC(W), .CMD_SECT(8'h30)) u_sect_batch_win (
    .clk(clk), .rst_n(rst_n), .seq_open(seq_open), .seq_sector(seq_sector),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_sector(wr_sector),
    .erase_done(erase_done), .start_pulse(start_pulse), .start_mask(start_mask),
    .abort_pulse(abort_pulse), .sts_closed(sts_closed), .sts_toggle(sts_toggle)
  );

  // row: {open sector[19:17], added sectors ascending[16:9], abort[8], expected start mask[7:0]}
  localparam int NV = 6;
  localparam logic [19:0] VEC [NV] = '{
    {3'd3, 8'h00, 1'b0, 8'h08},
    {3'd0, 8'h06, 1'b0, 8'h07},
    {3'd5, 8'h20, 1'b0, 8'h20},
    {3'd7, 8'h7F, 1'b0, 8'hFF},
    {3'd2, 8'h01, 1'b1, 8'h00},
    {3'd4, 8'h00, 1'b1, 8'h00}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all stimulus tasks start and end just after a falling edge
  task automatic open_win(input logic [2:0] s);
    seq_open = 1'b1; seq_sector = s;
    @(negedge clk);
    seq_open = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d, input logic [2:0] s);
    wr_valid = 1'b1; wr_data = d; wr_sector = s;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_start(input string req, input logic [7:0] exp_mask);
    int n = 1;
    while (!start_pulse && n < 64) begin
      @(negedge clk);
      n++;
    end
    chk(n == W + 1, {req, " window length"}, n, W + 1);
    chk(start_mask == exp_mask, {req, " start mask"}, start_mask, exp_mask);
    chk(sts_closed && sts_toggle, "R8 closed with start", {sts_closed, sts_toggle}, 2'b11);
    @(negedge clk);
    chk(!start_pulse && start_mask == 8'h00, "R11 single start cycle", {start_pulse, start_mask}, 0);
  endtask

  task automatic finish_erase();
    chk(sts_closed, "R8 closed until done", sts_closed, 1);
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
    chk(!sts_closed && !sts_toggle, "R9 idle after done", {sts_closed, sts_toggle}, 0);
  endtask

  task automatic expect_no_start(input string req, input int cycles);
    int seen = 0;
    for (int k = 0; k < cycles; k++) begin
      if (start_pulse) seen++;
      @(negedge clk);
    end
    chk(seen == 0, req, seen, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic [19:0] v;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({sts_closed, sts_toggle, start_pulse, abort_pulse} == 4'b0 && start_mask == 8'h00,
        "R1 reset outputs", {sts_closed, sts_toggle, start_pulse, abort_pulse, start_mask}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!sts_toggle, "R1 idle after reset", sts_toggle, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      open_win(v[19:17]);
      chk(sts_toggle && !sts_closed, "R2 window open", {sts_toggle, sts_closed}, 2'b10);
      for (int k = 0; k < 8; k++) begin
        if (v[9+k]) begin
          repeat (2) @(negedge clk);
          wr(8'h30, 3'(k));
          chk(!start_pulse && sts_toggle, "R4 add keeps window", {start_pulse, sts_toggle}, 1);
        end
      end
      if (v[8]) begin
        repeat (2) @(negedge clk);
        wr(8'hF0, 3'd0);
        chk(abort_pulse && !sts_toggle && !sts_closed, "R7 abort", {abort_pulse, sts_toggle}, 2'b10);
        @(negedge clk);
        chk(!abort_pulse, "R7 abort one cycle", abort_pulse, 0);
        expect_no_start("R7 no start after abort", W + 3);
      end else begin
        wait_start((v[16:9] == 8'h20) ? "R5" : (v[16:9] == 8'h7F) ? "R6" : "R3", v[7:0]);
        finish_erase();
      end
    end

    // R6 descending order, all sectors
    open_win(3'd7);
    for (int k = 6; k >= 0; k--) begin
      @(negedge clk);
      wr(8'h30, 3'(k));
    end
    wait_start("R6 descending", 8'hFF);
    finish_erase();

    // R10 erase code on the expiring edge
    open_win(3'd1);
    repeat (W - 1) @(negedge clk);
    wr(8'h30, 3'd6);
    chk(!start_pulse && sts_toggle && !sts_closed, "R10 add wins at expiry",
        {start_pulse, sts_toggle, sts_closed}, 3'b010);
    wait_start("R10 restarted", 8'h42);
    finish_erase();

    // R10 other code on the expiring edge
    open_win(3'd2);
    repeat (W - 1) @(negedge clk);
    wr(8'h90, 3'd2);
    chk(!start_pulse && abort_pulse && !sts_toggle, "R10 abort wins at expiry",
        {start_pulse, abort_pulse, sts_toggle}, 3'b010);
    expect_no_start("R10 no start after abort", W + 3);

    // R9 writes and opens ignored during erase
    open_win(3'd0);
    wait_start("R3 plain", 8'h01);
    wr(8'hF0, 3'd0);
    chk(!abort_pulse && sts_closed, "R9 other write ignored", {abort_pulse, sts_closed}, 2'b01);
    open_win(3'd3);
    chk(sts_closed, "R9 open ignored", sts_closed, 1);
    wr(8'h30, 3'd5);
    expect_no_start("R9 no start in erase", W + 3);
    finish_erase();
    open_win(3'd4);
    wait_start("R9 nothing carried over", 8'h10);
    finish_erase();

    // R12 writes while idle
    wr(8'h30, 3'd2);
    chk(!sts_toggle, "R12 idle write opens nothing", sts_toggle, 0);
    expect_no_start("R12 no start from idle", W + 3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule